// File: doc/BRIEF.md
# Lockable Configuration Register Bank

This block holds one control byte and a small set of 8-bit limit registers behind a plain register-access port. The port has an address, write data, a write strobe, a read strobe and registered read data. The control byte carries these fields:

- monitor enable
- a write-once freeze flag
- a read-only ready indication
- a full-speed override
- a power-reporting flag
- a spin-up bypass
- a bus-timeout enable

The block drives each of these fields out as a separate control signal.

Once the freeze flag is set, it stays set until reset. While it is set, the limit registers chosen by a parameter mask stop accepting writes. So do the power-reporting flag, the bus-timeout enable and the freeze flag itself. The monitor enable, the full-speed override and the spin-up bypass stay writable at all times. Writes that are refused finish normally and leave the stored value as it was.

While monitoring is off, the effective limits leave the block as the parameter defaults, and a duty-override output asks for full duty. The programmed values stay in storage and can be read back. When monitoring is switched on, the effective limits become the programmed values.

Top module: `cfg_lock_bank`

## Requirements
- R1: After reset the control byte at address 0 reads 0x04 while `ready_in` is 1. Each limit register (address k holds limit k-1, for k = 1..NUM_LIMITS) reads its default from LIMIT_DEFAULTS. All control outputs are 0, except `force_duty_max`, which is 1.
- R2: Control bit 1 (freeze) is set by writing 1 to it. Once set, it stays 1 until reset, whatever is written later. `lock_active` reflects it.
- R3: While frozen, a write to limit register i leaves it unchanged if LOCK_MASK[i] is 1. Limit registers whose mask bit is 0 stay writable.
- R4: While frozen, control bits 4 (power-reporting, `power_rpt`) and 6 (bus-timeout enable, `bus_to_en`) ignore writes.
- R5: Control bits 0 (monitor enable, `mon_start`), 3 (full-speed override, `force_full`) and 5 (spin-up bypass, `spinup_dis`) take the written value whether frozen or not.
- R6: Bit 2 of the control byte reads as `ready_in`, and writes to it have no effect. Bit 7 always reads 0.
- R7: While `mon_start` is 0, `eff_limits` equals LIMIT_DEFAULTS and `force_duty_max` is 1, and the programmed limit values remain readable. While `mon_start` is 1, `eff_limits` carries the programmed values and `force_duty_max` is 0.
- R8: `reg_rdata` updates one cycle after a cycle with `reg_re` high. It shows the value from before any write in that same cycle, and holds when `reg_re` is low. Unmapped addresses read 0 and ignore writes.
- R9: A write that sets the freeze flag also applies every other bit it carries. The freeze takes effect from the next write on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready_in | input | 1 | Ready indication shown in control bit 2 |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| mon_start | output | 1 | Monitor enable |
| lock_active | output | 1 | Freeze flag |
| force_full | output | 1 | Full-speed override |
| power_rpt | output | 1 | Power-reporting flag |
| spinup_dis | output | 1 | Spin-up bypass |
| bus_to_en | output | 1 | Bus-timeout enable |
| force_duty_max | output | 1 | Request full duty because monitoring is off |
| eff_limits | output | NUM_LIMITS*8 | Effective limits, limit 0 in the low byte |

## Verification
Two functions can fall in the same cycle.

- **Freeze and lockable bits together.** One control write sets the freeze flag and changes the lockable bits at once. The bench checks that these bits still take the new value, and that only a later write is refused.
- **Read and write together.** A read and a write hit the same limit address in one cycle. The returned byte must be the old value, and the new value must appear on the following read.

A behavioural reference model in the bench judges both cases on every clock.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  localparam int CFG_W   = 8;
  localparam int B_START = 0;
  localparam int B_LOCK  = 1;
  localparam int B_READY = 2;
  localparam int B_FULL  = 3;
  localparam int B_PWR   = 4;
  localparam int B_SPIN  = 5;
  localparam int B_BTO   = 6;

  // bits writable regardless of the freeze flag
  localparam logic [CFG_W-1:0] FREE_MASK  = 8'h29;
  // bits held in flops (ready and bit 7 are not stored)
  localparam logic [CFG_W-1:0] STORE_MASK = 8'h7B;

  function automatic logic [CFG_W-1:0] cfg_next(input logic [CFG_W-1:0] cur,
                                                 input logic [CFG_W-1:0] wd,
                                                 input logic locked);
    if (locked)
      return (cur & ~FREE_MASK) | (wd & FREE_MASK);
    return (wd & STORE_MASK) | (cur & (CFG_W'(1) << B_LOCK));
  endfunction

  function automatic logic [CFG_W-1:0] cfg_view(input logic [CFG_W-1:0] cur,
                                                 input logic rdy);
    return (cur & STORE_MASK) | (CFG_W'(rdy) << B_READY);
  endfunction
endpackage

// File: rtl/cfg_ctrl_reg.sv
module cfg_ctrl_reg
  import cfg_lock_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  input  logic             ready_in,
  output logic [CFG_W-1:0] cfg_q,
  output logic [CFG_W-1:0] cfg_rd
);
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = cfg_next(cfg_q, wdata, cfg_q[B_LOCK]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg_rd = cfg_view(cfg_q, ready_in);
endmodule

// File: rtl/limit_bank.sv
module limit_bank #(
  parameter int                    NUM_LIMITS     = 4,
  parameter logic [NUM_LIMITS*8-1:0] LIMIT_DEFAULTS = 32'h5A463C28,
  parameter logic [NUM_LIMITS-1:0] LOCK_MASK      = 4'b1011
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_LIMITS-1:0]   wr_sel,
  input  logic [7:0]              wdata,
  input  logic                    locked,
  output logic [NUM_LIMITS-1:0]   wr_en,
  output logic [NUM_LIMITS*8-1:0] lim_q
);
  for (genvar i = 0; i < NUM_LIMITS; i++) begin : g_lim
    if (LOCK_MASK[i]) begin : g_lockable
      assign wr_en[i] = wr_sel[i] & ~locked;
    end else begin : g_free
      assign wr_en[i] = wr_sel[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lim_q[i*8 +: 8] <= LIMIT_DEFAULTS[i*8 +: 8];
      else if (wr_en[i]) lim_q[i*8 +: 8] <= wdata;
    end
  end
endmodule

// File: rtl/cfg_lock_bank.sv
module cfg_lock_bank
  import cfg_lock_pkg::*;
#(
  parameter int                    NUM_LIMITS     = 4,
  parameter int                    ADDR_W         = 3,
  parameter logic [NUM_LIMITS*8-1:0] LIMIT_DEFAULTS = 32'h5A463C28,
  parameter logic [NUM_LIMITS-1:0] LOCK_MASK      = 4'b1011
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ready_in,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [7:0]              reg_wdata,
  input  logic                    reg_we,
  input  logic                    reg_re,
  output logic [7:0]              reg_rdata,
  output logic                    mon_start,
  output logic                    lock_active,
  output logic                    force_full,
  output logic                    power_rpt,
  output logic                    spinup_dis,
  output logic                    bus_to_en,
  output logic                    force_duty_max,
  output logic [NUM_LIMITS*8-1:0] eff_limits
);
  localparam int LIM_W = NUM_LIMITS * 8;

  logic [CFG_W-1:0]      cfg_q, cfg_rd;
  logic                  cfg_wr_hit;
  logic [NUM_LIMITS-1:0] lim_sel, lim_wr_en;
  logic [LIM_W-1:0]      lim_q;
  logic [7:0]            rd_val;

  assign cfg_wr_hit = reg_we && (reg_addr == '0);

  for (genvar i = 0; i < NUM_LIMITS; i++) begin : g_dec
    assign lim_sel[i] = reg_we && (reg_addr == ADDR_W'(i + 1));
  end

  cfg_ctrl_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_hit), .wdata(reg_wdata),
    .ready_in(ready_in), .cfg_q(cfg_q), .cfg_rd(cfg_rd)
  );

  limit_bank #(
    .NUM_LIMITS(NUM_LIMITS), .LIMIT_DEFAULTS(LIMIT_DEFAULTS), .LOCK_MASK(LOCK_MASK)
  ) u_lim (
    .clk(clk), .rst_n(rst_n), .wr_sel(lim_sel), .wdata(reg_wdata),
    .locked(cfg_q[B_LOCK]), .wr_en(lim_wr_en), .lim_q(lim_q)
  );

  always_comb begin
    rd_val = '0;
    if (reg_addr == '0) rd_val = cfg_rd;
    for (int i = 0; i < NUM_LIMITS; i++)
      if (reg_addr == ADDR_W'(i + 1)) rd_val = lim_q[i*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_val;
  end

  assign mon_start      = cfg_q[B_START];
  assign lock_active    = cfg_q[B_LOCK];
  assign force_full     = cfg_q[B_FULL];
  assign power_rpt      = cfg_q[B_PWR];
  assign spinup_dis     = cfg_q[B_SPIN];
  assign bus_to_en      = cfg_q[B_BTO];
  assign force_duty_max = ~cfg_q[B_START];
  assign eff_limits     = cfg_q[B_START] ? lim_q : LIMIT_DEFAULTS;
endmodule

// File: rtl/cfg_lock_bank_chk.sv
module cfg_lock_bank_chk #(
  parameter int                    NUM_LIMITS     = 4,
  parameter int                    ADDR_W         = 3,
  parameter logic [NUM_LIMITS*8-1:0] LIMIT_DEFAULTS = 32'h5A463C28,
  parameter logic [NUM_LIMITS-1:0] LOCK_MASK      = 4'b1011
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ready_in,
  input logic [ADDR_W-1:0]       reg_addr,
  input logic [7:0]              reg_wdata,
  input logic                    reg_we,
  input logic                    reg_re,
  input logic [7:0]              reg_rdata,
  input logic                    mon_start,
  input logic                    lock_active,
  input logic                    power_rpt,
  input logic                    bus_to_en,
  input logic [NUM_LIMITS*8-1:0] eff_limits,
  input logic [NUM_LIMITS*8-1:0] lim_q,
  input logic [NUM_LIMITS-1:0]   lim_wr_en
);
  // R2
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_active |=> lock_active);

  // R4
  locked_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_active |=> (power_rpt == $past(power_rpt)) && (bus_to_en == $past(bus_to_en)));

  // R5
  start_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == '0) |=> (mon_start == $past(reg_wdata[0])));

  // R6
  ready_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && reg_addr == '0) |=> (reg_rdata[2] == $past(ready_in)) && !reg_rdata[7]);

  // R7
  default_limits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_start |-> (eff_limits == LIMIT_DEFAULTS));

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re |=> $stable(reg_rdata));

  for (genvar i = 0; i < NUM_LIMITS; i++) begin : g_lim_chk
    // R3
    lim_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lim_wr_en[i] |=> (lim_q[i*8 +: 8] == $past(reg_wdata)));
    if (LOCK_MASK[i]) begin : g_locked
      // R3
      lim_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_active |=> $stable(lim_q[i*8 +: 8]));
    end
  end
endmodule

bind cfg_lock_bank cfg_lock_bank_chk #(
  .NUM_LIMITS(NUM_LIMITS), .ADDR_W(ADDR_W),
  .LIMIT_DEFAULTS(LIMIT_DEFAULTS), .LOCK_MASK(LOCK_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ready_in(ready_in), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
  .mon_start(mon_start), .lock_active(lock_active), .power_rpt(power_rpt),
  .bus_to_en(bus_to_en), .eff_limits(eff_limits), .lim_q(lim_q), .lim_wr_en(lim_wr_en)
);

// File: tb/cfg_lock_bank_tb.sv
module cfg_lock_bank_tb;
  localparam int NL = 4;
  localparam logic [NL*8-1:0] DEF = 32'h5A463C28;
  localparam logic [NL-1:0]   MSK = 4'b1011;

  logic clk = 0, rst_n = 0, ready_in = 1, reg_we = 0, reg_re = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic mon_start, lock_active, force_full, power_rpt, spinup_dis, bus_to_en, force_duty_max;
  logic [NL*8-1:0] eff_limits;

  int checks = 0, fails = 0;
  logic [7:0] m_cfg, m_rd;
  logic [7:0] m_lim [NL];

  always #2 clk = ~clk;

  cfg_lock_bank u_dut (
    .clk(clk), .rst_n(rst_n), .ready_in(ready_in), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .mon_start(mon_start), .lock_active(lock_active), .force_full(force_full),
    .power_rpt(power_rpt), .spinup_dis(spinup_dis), .bus_to_en(bus_to_en),
    .force_duty_max(force_duty_max), .eff_limits(eff_limits)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 0; m_rd = 0;
      for (int i = 0; i < NL; i++) m_lim[i] = DEF[i*8 +: 8];
    end else begin
      if (reg_re) begin
        if (reg_addr == 0) m_rd = {1'b0, m_cfg[6:3], ready_in, m_cfg[1:0]};
        else if (reg_addr <= NL) m_rd = m_lim[reg_addr - 1];
        else m_rd = 0;
      end
      if (reg_we) begin
        if (reg_addr == 0) begin
          if (m_cfg[1]) begin
            m_cfg[0] = reg_wdata[0]; m_cfg[3] = reg_wdata[3]; m_cfg[5] = reg_wdata[5];
          end else
            m_cfg = {1'b0, reg_wdata[6:3], 1'b0, reg_wdata[1:0]};
        end else if (reg_addr <= NL) begin
          if (!(m_cfg[1] && MSK[reg_addr - 1])) m_lim[reg_addr - 1] = reg_wdata;
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) if (rst_n) begin
    logic [NL*8-1:0] exp_eff;
    for (int i = 0; i < NL; i++) exp_eff[i*8 +: 8] = m_cfg[0] ? m_lim[i] : DEF[i*8 +: 8];
    chk("R8 rdata", reg_rdata, m_rd);
    chk("R2 lock", lock_active, m_cfg[1]);
    chk("R4 pwr/bto", {power_rpt, bus_to_en}, {m_cfg[4], m_cfg[6]});
    chk("R5 free bits", {mon_start, force_full, spinup_dis}, {m_cfg[0], m_cfg[3], m_cfg[5]});
    chk("R7 eff", eff_limits, exp_eff);
    chk("R7 duty", force_duty_max, !m_cfg[0]);
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    reg_addr = a; reg_re = 1;
    @(negedge clk); reg_re = 0;
    chk(req, reg_rdata, exp);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 outputs", {mon_start, lock_active, force_full, power_rpt, spinup_dis, bus_to_en, force_duty_max}, 7'b0000001);
    rd(0, 8'h04, "R1 cfg reset");
    rd(1, 8'h28, "R1 lim0"); rd(2, 8'h3C, "R1 lim1");
    rd(3, 8'h46, "R1 lim2"); rd(4, 8'h5A, "R1 lim3");
    rd(5, 8'h00, "R8 unmapped");
    ready_in = 0; rd(0, 8'h00, "R6 ready low"); ready_in = 1;
    wr(0, 8'hB9);
    rd(0, 8'h3D, "R6 bit7/bit2 ignore write");
    wr(1, 8'h11); wr(3, 8'h33);
    chk("R7 programmed eff", eff_limits, 32'h5A333C11);
    wr(0, 8'h38);
    chk("R7 defaults eff", eff_limits, DEF);
    rd(1, 8'h11, "R7 retained");
    wr(0, 8'h43);
    rd(0, 8'h47, "R9 same write lock");
    chk("R9 bto", bus_to_en, 1'b1);
    wr(0, 8'h10);
    rd(0, 8'h46, "R4 locked pwr");
    chk("R2 lock kept", lock_active, 1'b1);
    wr(0, 8'h29);
    rd(0, 8'h6F, "R5 free while locked");
    wr(1, 8'h99); rd(1, 8'h11, "R3 locked lim0");
    wr(3, 8'h77); rd(3, 8'h77, "R3 unlocked lim2");
    wr(4, 8'h55); rd(4, 8'h5A, "R3 locked lim3");
    reg_addr = 3; reg_wdata = 8'h88; reg_we = 1; reg_re = 1;
    @(negedge clk); reg_we = 0; reg_re = 0;
    chk("R8 read-before-write", reg_rdata, 8'h77);
    rd(3, 8'h88, "R8 new value");
    wr(6, 8'hFF); rd(6, 8'h00, "R8 unmapped write");
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    rd(0, 8'h04, "R2 reset clears lock");
    wr(1, 8'hAB); rd(1, 8'hAB, "R3 writable after reset");
    report();
  end
endmodule